// File: doc/BRIEF.md
# JTAG Single-Cycle Shift Engine

This block lets a host processor bit-bang a JTAG chain through a small register port, one TCK period per command. The host writes a 3-bit command that says what level to put on TMS, what level to put on TDI, and whether the level on TDO should be kept. The engine then runs a complete TCK period. It holds TCK low for a programmable number of system clocks while TMS and TDI settle. It then holds TCK high for the same number of clocks. It samples TDO on the same edge that takes TCK low again.

The host has one more register for the TCK half-period, counted in system clocks. It can read back the captured TDO bit and a busy flag. The host builds every TAP state walk and every shift out of a series of these commands. The engine knows nothing about TAP states.

Top module: `jtag_step`

## Requirements
- R1: When the engine accepts a command (wr_en_i high, wr_addr_i = 0, busy_o low at a clock edge), tms_o takes wr_data_i bit 0 on that edge. It keeps that value until the next command is accepted.
- R2: When the engine accepts a command, tdi_o takes wr_data_i bit 1 on that edge. It keeps that value until the next command is accepted.
- R3: When command bit 2 is set, the engine captures the tdo_i level present at the clock edge where tck_o falls. The captured bit becomes rd_data_o bit 0 on that same edge: 1 when tdo_i was high, 0 when it was low. A level that tdo_i had earlier in the period has no effect.
- R4: When command bit 2 is clear, rd_data_o reads 0 after the command completes, whatever the level on tdo_i.
- R5: tck_o is low whenever busy_o is low. With a half-period of D clocks and a command accepted at edge E0, tck_o rises at edge E0+D and falls at edge E0+2D. busy_o is high from E0 up to E0+2D and drops on the same edge as tck_o.
- R6: A write with wr_address_i = 1 while busy_o is low sets the half-period D to wr_data_i. A value of 0 is treated as 1. After reset, D is 2.
- R7: While busy_o is high, every write is ignored, to either address. The running period, the pin levels and the later half-period are all unchanged.
- R8: rd_data_o changes only on the edge where a command completes. Bits above bit 0 always read 0.
- R9: The reset (rst_ni low) sets busy_o to 0, tck_o to 0, tms_o to 1, tdi_o to 0 and rd_data_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe, sampled on the clock edge |
| wr_addr_i | input | 1 | Write target: 0 is the command, 1 is the half-period |
| wr_data_i | input | DATA_W | Write data |
| busy_o | output | 1 | A TCK period is in progress |
| rd_data_o | output | DATA_W | Captured TDO bit in bit 0, zero-extended |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to the chain |
| tdo_i | input | 1 | JTAG data from the chain |

## Verification
The hardest case to reach is a host write that lands while a period is running. The ignore rule only matters if the write would have changed the pins or the half-period. The bench therefore injects a command write and a half-period write in the middle of a long period, with different data. It then checks that the next period still uses the old half-period. The second hard case is the TDO sampling instant. The bench holds tdo_i at one level for most of the period and flips it just before the falling edge, in both directions. Only a capture at the fall can give the expected result.

// File: rtl/jtag_step_pkg.sv
package jtag_step_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HOLD
  } phase_e;

  // bit 2 rd, bit 1 tdi, bit 0 tms
  typedef struct packed {
    logic rd;
    logic tdi;
    logic tms;
  } cmd_t;
endpackage

// File: rtl/jtag_step_regs.sv
module jtag_step_regs #(
  parameter int DATA_W    = 8,
  parameter int DIV_RESET = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       busy_i,
  output logic                       cmd_go_o,
  output jtag_step_pkg::cmd_t        cmd_o,
  output logic [DATA_W-1:0]          div_o
);
  logic accept;
  logic [DATA_W-1:0] div_q;

  assign accept   = wr_en_i && !busy_i;
  assign cmd_go_o = accept && !wr_addr_i;
  assign cmd_o    = jtag_step_pkg::cmd_t'(wr_data_i[2:0]);
  assign div_o    = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DATA_W'(DIV_RESET);
    end else if (accept && wr_addr_i) begin
      // zero would stall the counter; clamp to one clock
      div_q <= (wr_data_i == '0) ? DATA_W'(1) : wr_data_i;
    end
  end
endmodule

// File: rtl/jtag_step_timer.sv
module jtag_step_timer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic              zero_o
);
  logic [DATA_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i - DATA_W'(1);
    end else if (!zero_o) begin
      cnt_q <= cnt_q - DATA_W'(1);
    end
  end
endmodule

// File: rtl/jtag_step_seq.sv
module jtag_step_seq (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_go_i,
  input  jtag_step_pkg::cmd_t cmd_i,
  input  logic                zero_i,
  input  logic                tdo_i,
  output logic                load_o,
  output logic                busy_o,
  output logic                tck_o,
  output logic                tms_o,
  output logic                tdi_o,
  output logic                result_o
);
  import jtag_step_pkg::*;

  phase_e phase_q;
  logic   rd_q;

  assign busy_o = (phase_q != PH_IDLE);
  assign load_o = (phase_q == PH_IDLE && cmd_go_i) ||
                  (phase_q == PH_SETUP && zero_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      rd_q     <= 1'b0;
      tck_o    <= 1'b0;
      tms_o    <= 1'b1;
      tdi_o    <= 1'b0;
      result_o <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (cmd_go_i) begin
            tms_o   <= cmd_i.tms;
            tdi_o   <= cmd_i.tdi;
            rd_q    <= cmd_i.rd;
            phase_q <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (zero_i) begin
            tck_o   <= 1'b1;
            phase_q <= PH_HOLD;
          end
        end
        PH_HOLD: begin
          if (zero_i) begin
            // capture on the edge that ends the period
            tck_o    <= 1'b0;
            result_o <= rd_q & tdo_i;
            phase_q  <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jtag_step.sv
module jtag_step #(
  parameter int DATA_W    = 8,
  parameter int DIV_RESET = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  import jtag_step_pkg::*;

  logic              cmd_go;
  cmd_t              cmd;
  logic [DATA_W-1:0] div;
  logic              load;
  logic              zero;
  logic              result;

  jtag_step_regs #(
    .DATA_W   (DATA_W),
    .DIV_RESET(DIV_RESET)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .busy_i   (busy_o),
    .cmd_go_o (cmd_go),
    .cmd_o    (cmd),
    .div_o    (div)
  );

  jtag_step_timer #(
    .DATA_W(DATA_W)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(div),
    .zero_o    (zero)
  );

  jtag_step_seq i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_go_i(cmd_go),
    .cmd_i   (cmd),
    .zero_i  (zero),
    .tdo_i   (tdo_i),
    .load_o  (load),
    .busy_o  (busy_o),
    .tck_o   (tck_o),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o),
    .result_o(result)
  );

  assign rd_data_o = {{(DATA_W-1){1'b0}}, result};
endmodule

// File: rtl/jtag_step_chk.sv
module jtag_step_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              tck_o,
  input logic              tms_o,
  input logic              tdi_o
);
  // R5
  tck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tck_o);

  // R5
  busy_ends_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $fell(tck_o));

  // R1
  tms_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tms_o));

  // R2
  tdi_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tdi_o));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(tck_o) |-> $stable(rd_data_o));
endmodule

bind jtag_step jtag_step_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .rd_data_o(rd_data_o),
  .tck_o    (tck_o),
  .tms_o    (tms_o),
  .tdi_o    (tdi_o)
);

// File: tb/test_jtag_step.sv
`timescale 1ns/1ps
module test_jtag_step;
  localparam int DATA_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic              wr_addr_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              busy_o;
  logic [DATA_W-1:0] rd_data_o;
  logic              tck_o, tms_o, tdi_o;
  logic              tdo_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int cur_div = 2;

  always #2.5 clk_i = ~clk_i;

  jtag_step #(.DATA_W(DATA_W), .DIV_RESET(2)) i_jtag_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .busy_o(busy_o), .rd_data_o(rd_data_o),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
  );

  // behavioural reference
  int m_div, m_left;
  bit m_busy, m_tck, m_tms, m_tdi, m_rd, m_res;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 2; m_left = 0; m_busy = 0; m_tck = 0;
      m_tms = 1; m_tdi = 0; m_rd = 0; m_res = 0;
    end else if (m_busy) begin
      m_left = m_left - 1;
      if (m_left == m_div) m_tck = 1;
      if (m_left == 0) begin
        m_tck = 0; m_busy = 0; m_res = m_rd ? tdo_i : 1'b0;
      end
    end else if (wr_en_i) begin
      if (!wr_addr_i) begin
        m_tms = wr_data_i[0]; m_tdi = wr_data_i[1]; m_rd = wr_data_i[2];
        m_busy = 1; m_left = 2 * m_div;
      end else begin
        m_div = (wr_data_i == 0) ? 1 : int'(wr_data_i);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(tms_o == m_tms, "R1 tms", tms_o, m_tms);
      chk(tdi_o == m_tdi, "R2 tdi", tdi_o, m_tdi);
      chk(tck_o == m_tck, "R5 tck", tck_o, m_tck);
      chk(busy_o == m_busy, "R7 busy", busy_o, m_busy);
      chk(rd_data_o == DATA_W'(m_res), "R3 R4 R8 result", rd_data_o, m_res);
    end
  end

  task automatic wr(input bit addr, input int data);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = addr; wr_data_i = DATA_W'(data);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic set_div(input int d);
    wr(1'b1, d);
    cur_div = (d == 0) ? 1 : d;
  endtask

  // runs one command; tdo flips to late just before the falling edge
  task automatic run_cmd(input int cmd, input bit early, input bit late,
                         input bit intrude, input string tag);
    int n;
    tdo_i = early;
    wr(1'b0, cmd);
    n = 1;
    forever begin
      if (n == 2 * cur_div) tdo_i = late;
      if (intrude && n == 2) begin
        wr_en_i = 1; wr_addr_i = 0; wr_data_i = DATA_W'(~cmd & 7);
      end
      if (intrude && n == 3) begin
        wr_addr_i = 1; wr_data_i = 8'd1;
      end
      if (intrude && n == 4) wr_en_i = 0;
      if (!busy_o) break;
      @(negedge clk_i);
      n++;
    end
    chk(n - 1 == 2 * cur_div, {tag, " R5 R6 busy length"}, n - 1, 2 * cur_div);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(busy_o == 0, "R9 busy", busy_o, 0);
    chk(tck_o == 0, "R9 tck", tck_o, 0);
    chk(tms_o == 1, "R9 tms", tms_o, 1);
    chk(tdi_o == 0, "R9 tdi", tdi_o, 0);
    chk(rd_data_o == 0, "R9 result", rd_data_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R6 default half-period, R3 capture high
    run_cmd(3'b101, 1'b0, 1'b1, 1'b0, "R6 default");
    chk(rd_data_o == 1, "R3 tdo high", rd_data_o, 1);
    chk(tms_o == 1 && tdi_o == 0, "R1 R2 pins 101", {tms_o, tdi_o}, 2);

    // R3 early level ignored
    run_cmd(3'b110, 1'b1, 1'b0, 1'b0, "R3 late low");
    chk(rd_data_o == 0, "R3 tdo low at fall", rd_data_o, 0);
    run_cmd(3'b100, 1'b0, 1'b1, 1'b0, "R3 late high");
    chk(rd_data_o == 1, "R3 tdo high at fall", rd_data_o, 1);

    // R4 no read with tdo high
    run_cmd(3'b011, 1'b1, 1'b1, 1'b0, "R4");
    chk(rd_data_o == 0, "R4 no read gives 0", rd_data_o, 0);
    chk(tms_o == 1 && tdi_o == 1, "R1 R2 pins 011", {tms_o, tdi_o}, 3);

    // R6 zero clamps to one
    set_div(0);
    run_cmd(3'b110, 1'b1, 1'b1, 1'b0, "R6 div0");
    chk(rd_data_o == 1, "R3 div1 capture", rd_data_o, 1);
    chk(tms_o == 0 && tdi_o == 1, "R1 R2 pins 110", {tms_o, tdi_o}, 1);

    // R6 larger half-period, R7 writes during busy
    set_div(5);
    run_cmd(3'b100, 1'b1, 1'b1, 1'b1, "R7 intrude");
    chk(tms_o == 0 && tdi_o == 0, "R7 pins kept", {tms_o, tdi_o}, 0);
    chk(rd_data_o == 1, "R7 result kept", rd_data_o, 1);
    repeat (4) @(negedge clk_i);
    chk(busy_o == 0, "R7 no queued command", busy_o, 0);
    run_cmd(3'b001, 1'b0, 1'b0, 1'b0, "R7 div kept");

    // R8 hold during next command and zero extension
    run_cmd(3'b100, 1'b1, 1'b1, 1'b0, "R8 setup");
    tdo_i = 0;
    wr(1'b0, 3'b000);
    repeat (4) @(negedge clk_i);
    chk(busy_o == 1, "R8 mid period busy", busy_o, 1);
    chk(rd_data_o == 8'd1, "R8 held mid period", rd_data_o, 1);
    while (busy_o) @(negedge clk_i);
    chk(rd_data_o == 8'd0, "R8 updated at end", rd_data_o, 0);

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule